// File: doc/BRIEF.md
# Page Permission and Fault Reporter

This block sits at the end of an address translation walk. It receives the leaf entry that the walk found and returns what that entry allows. It also receives the access type, the problem-state bit, a flag that selects process-scoped or partition-scoped checking, the permission set taken from the authority mask, and any fault cause the walk has already raised. From these it works out the read/write/execute permissions, decides whether the access is allowed, and builds the fault cause word for a refused access. The fault is routed to one of four fault classes: instruction or data, each in an ordinary or a hypervisor form. The matching fault-address and cause registers are then loaded. The block also merges its result with the result of an earlier stage: the permissions are ANDed and the smaller page size is kept.

A request enters over a valid/ready handshake and the result leaves over a second one. The output holds one result register. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, every response field stays unchanged and no new request is taken. The fault registers load in the cycle a faulting request is accepted.

Top module: `pgperm_fault_unit`

## Requirements
- R1: Entry bit 0 grants execute, bit 1 write, bit 2 read, and bit 3 marks a privileged page. A process-scoped check of a privileged page in problem state (`prob_state`=1) grants no permissions. In problem state, for a privileged page, or for a partition-scoped check (`part_scope`=1), the permissions are the entry's own read/write/execute bits.
- R2: A process-scoped check of a non-privileged page with `prob_state`=0 grants the entry's permissions ANDed with `amr_perm` (bit 2 read, bit 1 write, bit 0 execute).
- R3: `acc` encodes 0 read, 1 write, 2 fetch, and 3 counts as read. If the permission the access needs is not granted, the access faults and cause bit 0 (protection) is set.
- R4: A fetch from an entry whose attribute field (bits 5:4) equals 2'b11 faults with cause bit 1 (guarded no-execute) and without the protection bit. Reads and writes to such a page are checked only by R1–R3.
- R5: A nonzero `walk_cause` makes the access fault. The cause starts from `walk_cause`, and the entry is not checked.
- R6: A write that faults has cause bit 2 (store) ORed into its cause.
- R7: A partition-scoped fault with `table_entry`=1 has cause bit 3 (table fault) ORed in. For a process-scoped fault, `table_entry` has no effect.
- R8: `rsp_kind` is 0 for no fault, 1 for an instruction fault, 2 for a data fault, 3 for a hypervisor instruction fault and 4 for a hypervisor data fault. A fetch gives an instruction fault and any other access a data fault. Partition scope selects the hypervisor form.
- R9: A data fault loads `dfault_cause` with the cause and `dfault_addr` with `eff_addr`. An instruction fault loads `ifault_code` with the cause and leaves `dfault_cause` unchanged.
- R10: A hypervisor data fault loads `hfault_cause`, `hfault_addr` (with `eff_addr`) and `gfault_addr` (with `guest_addr`). A hypervisor instruction fault loads `gfault_addr` and `ifault_code`.
- R11: When there is no fault, `rsp_perm` is `prior_perm` ANDed with the granted permissions. On a fault, `rsp_perm` is 0. `rsp_psize` is always the smaller of `prior_psize` and `leaf_psize`.
- R12: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0, the response fields hold, and the fault registers do not change.
- R13: After reset, `rsp_valid` is 0, `req_ready` is 1 and all fault registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| entry | input | ENTRY_W (8) | Leaf table entry |
| acc | input | 2 | Access type |
| prob_state | input | 1 | Problem (user) state |
| part_scope | input | 1 | 1 = partition-scoped check |
| amr_perm | input | 3 | Authority-mask permission set |
| walk_cause | input | CAUSE_W (16) | Fault cause from the walk, 0 if none |
| table_entry | input | 1 | The translated address was a table entry |
| eff_addr | input | EA_W (32) | Faulting effective address |
| guest_addr | input | RA_W (32) | Guest real address |
| prior_perm | input | 3 | Permissions from the earlier stage |
| prior_psize | input | PS_W (6) | Page size log2 from the earlier stage |
| leaf_psize | input | PS_W (6) | Page size log2 of this leaf |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_fault | output | 1 | Access refused |
| rsp_kind | output | 3 | Fault class |
| rsp_cause | output | CAUSE_W (16) | Fault cause word |
| rsp_perm | output | 3 | Final permissions |
| rsp_psize | output | PS_W (6) | Final page size |
| dfault_cause | output | CAUSE_W (16) | Data fault cause register |
| dfault_addr | output | EA_W (32) | Data fault address register |
| hfault_cause | output | CAUSE_W (16) | Hypervisor data fault cause register |
| hfault_addr | output | EA_W (32) | Hypervisor data fault address register |
| gfault_addr | output | RA_W (32) | Guest real address register |
| ifault_code | output | CAUSE_W (16) | Instruction fault error code |

## Verification
The vectors cover every combination of problem state, privileged page and scope that picks a different permission source. The same entry is run with different authority masks, so a wrong AND or a skipped mask shows up. Non-idempotent pages are hit with a fetch and with a read, which tells the guard path apart from the protection path. Walk causes are sent with the write and table-entry flags set, which checks that the decorating bits are still added. A mask-free partition fetch and access type 3 separate the scope and encoding decode. A stalled output with a faulting request waiting behind it shows that neither the result nor the fault registers move until the handshake completes.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FK_NONE   = 3'd0,
    FK_INSTR  = 3'd1,
    FK_DATA   = 3'd2,
    FK_HINSTR = 3'd3,
    FK_HDATA  = 3'd4
  } fkind_e;

  localparam int EB_X      = 0;
  localparam int EB_W      = 1;
  localparam int EB_R      = 2;
  localparam int EB_PRIV   = 3;
  localparam int EB_ATT_LO = 4;
  localparam logic [1:0] ATT_NIO = 2'b11;

  localparam int CB_PROT  = 0;
  localparam int CB_GUARD = 1;
  localparam int CB_STORE = 2;
  localparam int CB_TABLE = 3;

  localparam int PERM_W = 3;
endpackage

// File: rtl/pgperm_eval.sv
module pgperm_eval
  import pgperm_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int CAUSE_W = 16
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [1:0]         acc,
  input  logic               prob_state,
  input  logic               part_scope,
  input  logic [PERM_W-1:0]  amr_perm,
  input  logic [CAUSE_W-1:0] walk_cause,
  output logic               fault,
  output logic [CAUSE_W-1:0] base_cause,
  output logic [PERM_W-1:0]  granted
);
  logic [1:0]        attr;
  logic [PERM_W-1:0] ent_perm;
  logic [PERM_W-1:0] perm;
  logic [PERM_W-1:0] need;
  logic              priv_pg;

  assign attr     = entry[EB_ATT_LO +: 2];
  assign ent_perm = {entry[EB_R], entry[EB_W], entry[EB_X]};
  assign priv_pg  = entry[EB_PRIV];

  always_comb begin
    if (!part_scope && priv_pg && prob_state)
      perm = '0;
    else if (prob_state || priv_pg || part_scope)
      perm = ent_perm;
    else
      perm = ent_perm & amr_perm;
  end

  always_comb begin
    unique case (acc_e'(acc))
      ACC_WRITE: need = 3'b010;
      ACC_FETCH: need = 3'b001;
      default:   need = 3'b100;
    endcase
  end

  always_comb begin
    fault      = 1'b0;
    base_cause = '0;
    if (walk_cause != '0) begin
      fault      = 1'b1;
      base_cause = walk_cause;
    end else if (acc_e'(acc) == ACC_FETCH && attr == ATT_NIO) begin
      fault                = 1'b1;
      base_cause[CB_GUARD] = 1'b1;
    end else if ((need & perm) == '0) begin
      fault               = 1'b1;
      base_cause[CB_PROT] = 1'b1;
    end
    granted = fault ? '0 : perm;
  end
endmodule

// File: rtl/pgperm_route.sv
module pgperm_route
  import pgperm_pkg::*;
#(
  parameter int CAUSE_W = 16
) (
  input  logic               fault,
  input  logic [CAUSE_W-1:0] base_cause,
  input  logic [1:0]         acc,
  input  logic               part_scope,
  input  logic               table_entry,
  output logic [CAUSE_W-1:0] cause,
  output fkind_e             kind
);
  logic is_fetch;
  assign is_fetch = (acc_e'(acc) == ACC_FETCH);

  always_comb begin
    cause = base_cause;
    if (fault && part_scope && table_entry) cause[CB_TABLE] = 1'b1;
    if (fault && acc_e'(acc) == ACC_WRITE)  cause[CB_STORE] = 1'b1;
    if (!fault)
      kind = FK_NONE;
    else if (is_fetch)
      kind = part_scope ? FK_HINSTR : FK_INSTR;
    else
      kind = part_scope ? FK_HDATA : FK_DATA;
  end
endmodule

// File: rtl/pgperm_fregs.sv
module pgperm_fregs
  import pgperm_pkg::*;
#(
  parameter int CAUSE_W = 16,
  parameter int EA_W    = 32,
  parameter int RA_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  fkind_e             kind,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [EA_W-1:0]    eff_addr,
  input  logic [RA_W-1:0]    guest_addr,
  output logic [CAUSE_W-1:0] dfault_cause,
  output logic [EA_W-1:0]    dfault_addr,
  output logic [CAUSE_W-1:0] hfault_cause,
  output logic [EA_W-1:0]    hfault_addr,
  output logic [RA_W-1:0]    gfault_addr,
  output logic [CAUSE_W-1:0] ifault_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dfault_cause <= '0;
      dfault_addr  <= '0;
      hfault_cause <= '0;
      hfault_addr  <= '0;
      gfault_addr  <= '0;
      ifault_code  <= '0;
    end else if (load) begin
      unique case (kind)
        FK_DATA: begin
          dfault_cause <= cause;
          dfault_addr  <= eff_addr;
        end
        FK_INSTR: ifault_code <= cause;
        FK_HDATA: begin
          hfault_cause <= cause;
          hfault_addr  <= eff_addr;
          gfault_addr  <= guest_addr;
        end
        FK_HINSTR: begin
          gfault_addr <= guest_addr;
          ifault_code <= cause;
        end
        default: ;
      endcase
    end
  end

  p_ifault_keeps_dcause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && kind == FK_INSTR) |=> $stable(dfault_cause));

  p_idle_keeps_regs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dfault_cause) && $stable(hfault_cause) && $stable(gfault_addr)));
endmodule

// File: rtl/pgperm_fault_unit.sv
module pgperm_fault_unit
  import pgperm_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int CAUSE_W = 16,
  parameter int EA_W    = 32,
  parameter int RA_W    = 32,
  parameter int PS_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [1:0]         acc,
  input  logic               prob_state,
  input  logic               part_scope,
  input  logic [2:0]         amr_perm,
  input  logic [CAUSE_W-1:0] walk_cause,
  input  logic               table_entry,
  input  logic [EA_W-1:0]    eff_addr,
  input  logic [RA_W-1:0]    guest_addr,
  input  logic [2:0]         prior_perm,
  input  logic [PS_W-1:0]    prior_psize,
  input  logic [PS_W-1:0]    leaf_psize,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [2:0]         rsp_kind,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [2:0]         rsp_perm,
  output logic [PS_W-1:0]    rsp_psize,
  output logic [CAUSE_W-1:0] dfault_cause,
  output logic [EA_W-1:0]    dfault_addr,
  output logic [CAUSE_W-1:0] hfault_cause,
  output logic [EA_W-1:0]    hfault_addr,
  output logic [RA_W-1:0]    gfault_addr,
  output logic [CAUSE_W-1:0] ifault_code
);
  logic               ev_fault;
  logic [CAUSE_W-1:0] ev_cause;
  logic [PERM_W-1:0]  ev_perm;
  logic [CAUSE_W-1:0] rt_cause;
  fkind_e             rt_kind;
  logic               accept;
  logic [PS_W-1:0]    min_psize;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign min_psize = (prior_psize < leaf_psize) ? prior_psize : leaf_psize;

  pgperm_eval #(.ENTRY_W(ENTRY_W), .CAUSE_W(CAUSE_W)) u_eval (
    .entry(entry), .acc(acc), .prob_state(prob_state), .part_scope(part_scope),
    .amr_perm(amr_perm), .walk_cause(walk_cause),
    .fault(ev_fault), .base_cause(ev_cause), .granted(ev_perm)
  );

  pgperm_route #(.CAUSE_W(CAUSE_W)) u_route (
    .fault(ev_fault), .base_cause(ev_cause), .acc(acc), .part_scope(part_scope),
    .table_entry(table_entry), .cause(rt_cause), .kind(rt_kind)
  );

  pgperm_fregs #(.CAUSE_W(CAUSE_W), .EA_W(EA_W), .RA_W(RA_W)) u_fregs (
    .clk(clk), .rst_n(rst_n), .load(accept), .kind(rt_kind), .cause(rt_cause),
    .eff_addr(eff_addr), .guest_addr(guest_addr),
    .dfault_cause(dfault_cause), .dfault_addr(dfault_addr),
    .hfault_cause(hfault_cause), .hfault_addr(hfault_addr),
    .gfault_addr(gfault_addr), .ifault_code(ifault_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_kind  <= 3'(FK_NONE);
      rsp_cause <= '0;
      rsp_perm  <= '0;
      rsp_psize <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= ev_fault;
      rsp_kind  <= 3'(rt_kind);
      rsp_cause <= rt_cause;
      rsp_perm  <= prior_perm & ev_perm;
      rsp_psize <= min_psize;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cause) &&
                                   $stable(rsp_perm) && $stable(rsp_kind)));

  p_fault_no_perm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_perm == '0);

  p_kind_matches_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_kind != 3'(FK_NONE))));

  p_fault_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_cause != '0);
endmodule

// File: tb/pgperm_fault_unit_tb.sv
module pgperm_fault_unit_tb;
  typedef struct packed {
    logic [7:0]  ent;
    logic [1:0]  acc;
    logic        pr;
    logic        part;
    logic [2:0]  amr;
    logic [15:0] walk;
    logic        tbl;
    logic [2:0]  pperm;
    logic [5:0]  ppsz;
    logic [5:0]  lpsz;
    logic        xfault;
    logic [2:0]  xkind;
    logic [15:0] xcause;
    logic [2:0]  xperm;
    logic [5:0]  xpsz;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h07, 2'd0, 1'b1, 1'b0, 3'b000, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b0, 3'd0, 16'h0000, 3'b111, 6'd12}, // R1 pr, direct
    '{8'h07, 2'd0, 1'b0, 1'b0, 3'b001, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b1, 3'd2, 16'h0001, 3'b000, 6'd12}, // R2 R3 masked read
    '{8'h07, 2'd1, 1'b0, 1'b0, 3'b010, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b0, 3'd0, 16'h0000, 3'b010, 6'd12}, // R2 masked write ok
    '{8'h0F, 2'd2, 1'b1, 1'b0, 3'b111, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b1, 3'd1, 16'h0001, 3'b000, 6'd12}, // R1 priv+pr
    '{8'h0F, 2'd0, 1'b0, 1'b0, 3'b000, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b0, 3'd0, 16'h0000, 3'b111, 6'd12}, // R1 priv no mask
    '{8'h0F, 2'd1, 1'b1, 1'b1, 3'b000, 16'h0000, 1'b0, 3'b101, 6'd9,  6'd12, 1'b0, 3'd0, 16'h0000, 3'b101, 6'd9 }, // R11 combine
    '{8'h05, 2'd1, 1'b0, 1'b1, 3'b111, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b1, 3'd4, 16'h0005, 3'b000, 6'd12}, // R6 R10
    '{8'h35, 2'd2, 1'b1, 1'b0, 3'b111, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b1, 3'd1, 16'h0002, 3'b000, 6'd12}, // R4 guard
    '{8'h37, 2'd2, 1'b0, 1'b1, 3'b111, 16'h0000, 1'b1, 3'b111, 6'd21, 6'd12, 1'b1, 3'd3, 16'h000A, 3'b000, 6'd12}, // R4 R7 hyp instr
    '{8'h35, 2'd0, 1'b1, 1'b0, 3'b000, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b0, 3'd0, 16'h0000, 3'b101, 6'd12}, // R4 read on NIO
    '{8'h07, 2'd1, 1'b1, 1'b0, 3'b111, 16'h0100, 1'b0, 3'b111, 6'd21, 6'd12, 1'b1, 3'd2, 16'h0104, 3'b000, 6'd12}, // R5 walk+store
    '{8'h07, 2'd0, 1'b1, 1'b1, 3'b111, 16'h0200, 1'b1, 3'b111, 6'd21, 6'd12, 1'b1, 3'd4, 16'h0208, 3'b000, 6'd12}, // R5 R7 walk+table
    '{8'h03, 2'd3, 1'b1, 1'b0, 3'b111, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b1, 3'd2, 16'h0001, 3'b000, 6'd12}, // R3 acc3 read
    '{8'h06, 2'd1, 1'b1, 1'b0, 3'b000, 16'h0000, 1'b1, 3'b111, 6'd21, 6'd12, 1'b0, 3'd0, 16'h0000, 3'b110, 6'd12}, // R7 proc table ignored
    '{8'h07, 2'd1, 1'b0, 1'b0, 3'b100, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b1, 3'd2, 16'h0005, 3'b000, 6'd12}, // R2 R6
    '{8'h03, 2'd2, 1'b0, 1'b1, 3'b000, 16'h0000, 1'b0, 3'b111, 6'd21, 6'd12, 1'b0, 3'd0, 16'h0000, 3'b011, 6'd12}  // R1 part ignores mask
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_fault;
  logic [7:0] entry = '0;
  logic [1:0] acc = '0;
  logic prob_state = 1'b0, part_scope = 1'b0, table_entry = 1'b0;
  logic [2:0] amr_perm = '0, prior_perm = '0;
  logic [15:0] walk_cause = '0;
  logic [31:0] eff_addr = '0, guest_addr = '0;
  logic [5:0] prior_psize = '0, leaf_psize = '0;
  logic [2:0] rsp_kind, rsp_perm;
  logic [15:0] rsp_cause, dfault_cause, hfault_cause, ifault_code;
  logic [5:0] rsp_psize;
  logic [31:0] dfault_addr, hfault_addr, gfault_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] m_dc = '0, m_hc = '0, m_ic = '0;
  logic [31:0] m_da = '0, m_ha = '0, m_ga = '0;

  always #4 clk = ~clk;

  pgperm_fault_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .entry(entry), .acc(acc), .prob_state(prob_state), .part_scope(part_scope),
    .amr_perm(amr_perm), .walk_cause(walk_cause), .table_entry(table_entry),
    .eff_addr(eff_addr), .guest_addr(guest_addr), .prior_perm(prior_perm),
    .prior_psize(prior_psize), .leaf_psize(leaf_psize),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_kind(rsp_kind), .rsp_cause(rsp_cause), .rsp_perm(rsp_perm),
    .rsp_psize(rsp_psize), .dfault_cause(dfault_cause), .dfault_addr(dfault_addr),
    .hfault_cause(hfault_cause), .hfault_addr(hfault_addr),
    .gfault_addr(gfault_addr), .ifault_code(ifault_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int i);
    entry = VEC[i].ent; acc = VEC[i].acc; prob_state = VEC[i].pr;
    part_scope = VEC[i].part; amr_perm = VEC[i].amr; walk_cause = VEC[i].walk;
    table_entry = VEC[i].tbl; prior_perm = VEC[i].pperm;
    prior_psize = VEC[i].ppsz; leaf_psize = VEC[i].lpsz;
    eff_addr = 32'h1000_0000 + 32'(i * 16);
    guest_addr = 32'h2000_0000 + 32'(i);
  endtask

  task automatic model_update(input int i);
    case (VEC[i].xkind)
      3'd1: m_ic = VEC[i].xcause;
      3'd2: begin m_dc = VEC[i].xcause; m_da = 32'h1000_0000 + 32'(i * 16); end
      3'd3: begin m_ga = 32'h2000_0000 + 32'(i); m_ic = VEC[i].xcause; end
      3'd4: begin m_hc = VEC[i].xcause; m_ha = 32'h1000_0000 + 32'(i * 16);
                  m_ga = 32'h2000_0000 + 32'(i); end
      default: ;
    endcase
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " R9 dcause"}, 32'(dfault_cause), 32'(m_dc));
    chk({tag, " R9 daddr"}, dfault_addr, m_da);
    chk({tag, " R9 icode"}, 32'(ifault_code), 32'(m_ic));
    chk({tag, " R10 hcause"}, 32'(hfault_cause), 32'(m_hc));
    chk({tag, " R10 haddr"}, hfault_addr, m_ha);
    chk({tag, " R10 gaddr"}, gfault_addr, m_ga);
  endtask

  task automatic check_rsp(input int i);
    chk($sformatf("v%0d R8 valid", i), 32'(rsp_valid), 32'd1);
    chk($sformatf("v%0d R3 fault", i), 32'(rsp_fault), 32'(VEC[i].xfault));
    chk($sformatf("v%0d R8 kind", i), 32'(rsp_kind), 32'(VEC[i].xkind));
    chk($sformatf("v%0d R6 cause", i), 32'(rsp_cause), 32'(VEC[i].xcause));
    chk($sformatf("v%0d R11 perm", i), 32'(rsp_perm), 32'(VEC[i].xperm));
    chk($sformatf("v%0d R11 psize", i), 32'(rsp_psize), 32'(VEC[i].xpsz));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R13 req_ready", 32'(req_ready), 32'd1);
    check_regs("R13");

    for (int i = 0; i < NV; i++) begin
      drive(i);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      model_update(i);
      check_rsp(i);
      check_regs($sformatf("v%0d", i));
    end
    @(negedge clk);
    chk("R12 drained", 32'(rsp_valid), 32'd0);

    // R12 back-pressure: stall with a faulting request waiting
    rsp_ready = 1'b0;
    drive(0);
    req_valid = 1'b1;
    @(negedge clk);
    model_update(0);
    chk("R12 ready low", 32'(req_ready), 32'd0);
    drive(1);
    @(negedge clk);
    chk("R12 hold perm", 32'(rsp_perm), 32'd7);
    chk("R12 hold fault", 32'(rsp_fault), 32'd0);
    chk("R12 hold valid", 32'(rsp_valid), 32'd1);
    check_regs("R12 stalled");
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    model_update(1);
    check_rsp(1);
    check_regs("R12 released");
    @(negedge clk);
    chk("R12 empty", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule